// File: doc/BRIEF.md
# Thermal Trip Point Register

This block is a 32-bit control and status register that sits beside an on-die thermal sensor. Software programs three 8-bit trip targets through it: an auxiliary point, a hot point and a catastrophic point. The stored targets are also driven out continuously so that threshold comparators elsewhere can use them. The register also reports a signed, saturated temperature relative to the hot trip target, which is computed from the most recent sensor sample.

Writes come through a simple register port with one byte enable per 8-bit field. An external lock input freezes the hot and catastrophic targets against writes. The auxiliary target stays writable at all times. A mode input selects what the top byte reports. In thermometer mode it reports the saturated difference between the sensor and the hot target. In analog mode it reports the hot target itself. Readback is combinational from the stored state and the mode input.

Top module: `thermal_trip_reg`

## Requirements
- R1: `rd_data` is laid out as relative temperature in bits 31:24, auxiliary target in bits 23:16, hot target in bits 15:8 and catastrophic target in bits 7:0. `aux_trip`, `hot_trip` and `cat_trip` always equal the stored targets.
- R2: A synchronous active-high `rst` clears every target and the stored sensor sample, so `rd_data` reads 0 after reset.
- R3: In thermometer mode (`mode_analog` = 0), bits 31:24 hold the two's-complement value of (last sensor sample − hot target). The value is positive when the sample is above the hot target.
- R4: That difference saturates to the range −127 to +127. The code 0x80 (−128) is never reported in thermometer mode, so a difference of −255 reads 0x81.
- R5: In analog mode (`mode_analog` = 1), bits 31:24 return the hot target value.
- R6: While `lock` is 1 in the write cycle, writes to the hot and catastrophic targets leave them unchanged, with no error indication. The auxiliary target is still written.
- R7: Each byte enable `wr_be[i]` gates field i on its own. Write data for bits 31:24 is ignored.
- R8: The sensor sample is taken only when `sens_valid` is 1 and is held between strobes. A rewrite of the hot target changes the reported difference in the cycle after the write.
- R9: An enabled, unlocked write makes the new field value visible on `rd_data` and on the trip outputs from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-good reset |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 4 | Byte enables, bit i selects bits 8i+7:8i |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register readback |
| sens_temp | input | 8 | Unsigned sensor reading |
| sens_valid | input | 1 | Sensor sample strobe |
| mode_analog | input | 1 | 1 = analog mode, 0 = thermometer mode |
| lock | input | 1 | Freezes hot and catastrophic targets |
| aux_trip | output | 8 | Auxiliary target to comparators |
| hot_trip | output | 8 | Hot target to comparators |
| cat_trip | output | 8 | Catastrophic target to comparators |

## Verification
The bench builds the block with its default 8-bit field width, so the full 0 to 255 range of both the sensor and the hot target is covered. With that width, random stimulus often drives the 9-bit difference past both saturation bounds. Directed vectors add the extreme differences of +255 and −255, the −128 case, and the hold and recompute behaviour of the sample across writes, strobes and lock changes.

// File: rtl/ttrip_pkg.sv
package ttrip_pkg;
    // Default width of one register field
    parameter int unsigned TT_FIELD_W = 8;

    // Field slots inside the register word (order is the readback layout)
    typedef enum logic [1:0] {
        SLOT_CAT = 2'd0,
        SLOT_HOT = 2'd1,
        SLOT_AUX = 2'd2,
        SLOT_REL = 2'd3
    } tt_slot_e;

    localparam int unsigned TT_NUM_SLOTS   = 4;
    localparam int unsigned TT_NUM_TARGETS = 3;

    // A slot is write-protected by the lock input unless it is the auxiliary one
    function automatic bit slot_lockable(input int unsigned idx);
        return idx != int'(SLOT_AUX);
    endfunction
endpackage

// File: rtl/ttrip_field.sv
module ttrip_field #(
    parameter int unsigned W        = 8,
    parameter bit          LOCKABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         be,
    input  logic [W-1:0] wdata,
    input  logic         lock,
    output logic [W-1:0] q
);
    logic blocked;
    logic take;

    assign blocked = LOCKABLE && lock;
    assign take    = wr_en && be && !blocked;

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (take) q <= wdata;
    end

    // Field clears on reset
    assert_reset_clear_R2: assert property (@(posedge clk) rst |=> (q == '0));

    // Locked write leaves the field untouched
    generate
        if (LOCKABLE) begin : g_lock_chk
            assert_locked_hold_R6: assert property (@(posedge clk) disable iff (rst)
                (wr_en && be && lock) |=> $stable(q));
        end
    endgenerate

    // Disabled byte lane leaves the field untouched
    assert_be_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (!be || !wr_en) |=> $stable(q));

    // Accepted write lands in the next cycle
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && be && !(LOCKABLE && lock)) |=> (q == $past(wdata)));
endmodule

// File: rtl/ttrip_reltemp.sv
module ttrip_reltemp #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sens_temp,
    input  logic         sens_valid,
    input  logic [W-1:0] hot,
    input  logic         mode_analog,
    output logic [W-1:0] rel
);
    localparam int DW      = W + 1;
    localparam int SAT_MAX = (1 << (W - 1)) - 1;

    localparam logic signed [DW-1:0] POS_LIM = DW'(SAT_MAX);
    localparam logic signed [DW-1:0] NEG_LIM = -DW'(SAT_MAX);
    localparam logic [W-1:0]         MIN_CODE = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0]          sample_q;
    logic signed [DW-1:0]  diff;
    logic signed [DW-1:0]  clipped;

    always_ff @(posedge clk) begin
        if (rst)             sample_q <= '0;
        else if (sens_valid) sample_q <= sens_temp;
    end

    always_comb begin
        diff = $signed({1'b0, sample_q}) - $signed({1'b0, hot});
        if (diff > POS_LIM)      clipped = POS_LIM;
        else if (diff < NEG_LIM) clipped = NEG_LIM;
        else                     clipped = diff;
    end

    assign rel = mode_analog ? hot : clipped[W-1:0];

    // Symmetric clip: the most negative code never appears in thermometer mode
    assert_no_min_code_R4: assert property (@(posedge clk) disable iff (rst)
        !mode_analog |-> (rel != MIN_CODE));

    // Sign follows the comparison of the fresh sample with the hot target
    assert_sign_above_R3: assert property (@(posedge clk) disable iff (rst)
        (sens_valid && sens_temp > hot) ##1 ($stable(hot) && !mode_analog)
            |-> (!rel[W-1] && rel != '0));
    assert_sign_below_R3: assert property (@(posedge clk) disable iff (rst)
        (sens_valid && sens_temp < hot) ##1 ($stable(hot) && !mode_analog)
            |-> rel[W-1]);

    // Without a strobe or a hot rewrite the reported value holds
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!sens_valid && !mode_analog) ##1 ($stable(hot) && !mode_analog)
            |-> $stable(rel));
endmodule

// File: rtl/thermal_trip_reg.sv
module thermal_trip_reg
    import ttrip_pkg::*;
#(
    parameter int unsigned FIELD_W = TT_FIELD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [3:0]           wr_be,
    input  logic [4*FIELD_W-1:0] wr_data,
    output logic [4*FIELD_W-1:0] rd_data,
    input  logic [FIELD_W-1:0]   sens_temp,
    input  logic                 sens_valid,
    input  logic                 mode_analog,
    input  logic                 lock,
    output logic [FIELD_W-1:0]   aux_trip,
    output logic [FIELD_W-1:0]   hot_trip,
    output logic [FIELD_W-1:0]   cat_trip
);
    localparam int unsigned REG_W = TT_NUM_SLOTS * FIELD_W;

    logic [FIELD_W-1:0] target [TT_NUM_TARGETS];
    logic [FIELD_W-1:0] rel;

    generate
        for (genvar gi = 0; gi < TT_NUM_TARGETS; gi++) begin : g_target
            ttrip_field #(
                .W        (FIELD_W),
                .LOCKABLE (slot_lockable(gi))
            ) u_field (
                .clk   (clk),
                .rst   (rst),
                .wr_en (wr_en),
                .be    (wr_be[gi]),
                .wdata (wr_data[gi*FIELD_W +: FIELD_W]),
                .lock  (lock),
                .q     (target[gi])
            );
        end
    endgenerate

    ttrip_reltemp #(.W(FIELD_W)) u_rel (
        .clk         (clk),
        .rst         (rst),
        .sens_temp   (sens_temp),
        .sens_valid  (sens_valid),
        .hot         (target[SLOT_HOT]),
        .mode_analog (mode_analog),
        .rel         (rel)
    );

    // Top lane write data and enable are deliberately unused
    logic unused_top;
    assign unused_top = wr_be[SLOT_REL] ^ (^wr_data[REG_W-1 -: FIELD_W]);

    assign cat_trip = target[SLOT_CAT];
    assign hot_trip = target[SLOT_HOT];
    assign aux_trip = target[SLOT_AUX];
    assign rd_data  = {rel, target[SLOT_AUX], target[SLOT_HOT], target[SLOT_CAT]};

    // Analog readback tracks a hot target rewrite into the next cycle
    assert_analog_hot_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_be[SLOT_HOT] && !lock) ##1 mode_analog
            |-> (rd_data[REG_W-1 -: FIELD_W] == $past(wr_data[SLOT_HOT*FIELD_W +: FIELD_W])));

    // Exported aux target is observed in its readback slot
    assert_aux_export_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_be[SLOT_AUX]) |=> (aux_trip == rd_data[SLOT_AUX*FIELD_W +: FIELD_W]));
endmodule

// File: tb/thermal_trip_reg_bench.sv
`timescale 1ns/1ps
module thermal_trip_reg_bench;
    localparam int W = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_be = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [7:0]    sens_temp = '0;
    logic          sens_valid = 1'b0;
    logic          mode_analog = 1'b0;
    logic          lock = 1'b0;
    logic [7:0]    aux_trip, hot_trip, cat_trip;

    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    // Bench model state
    int m_aux, m_hot, m_cat, m_samp;

    always #5 clk = ~clk;

    thermal_trip_reg u_thermal_trip_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_data), .sens_temp(sens_temp), .sens_valid(sens_valid),
        .mode_analog(mode_analog), .lock(lock),
        .aux_trip(aux_trip), .hot_trip(hot_trip), .cat_trip(cat_trip)
    );

    function automatic int sat_diff(input int s, input int h);
        int d = s - h;
        if (d > 127)  return 127;
        if (d < -127) return -127;
        return d;
    endfunction

    function automatic logic [7:0] exp_rel();
        if (mode_analog) return 8'(m_hot);
        return 8'(sat_diff(m_samp, m_hot));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare every visible output with the model, sampled at the falling edge
    task automatic check_all(input string rel_tag, input string tgt_tag);
        logic [31:0] e;
        e = {exp_rel(), 8'(m_aux), 8'(m_hot), 8'(m_cat)};
        chk(rel_tag, 32'(rd_data[31:24]), 32'(e[31:24]));
        chk(tgt_tag, 32'(rd_data[23:0]),  32'(e[23:0]));
        chk("R1 trip outputs", {8'h0, aux_trip, hot_trip, cat_trip}, {8'h0, e[23:0]});
    endtask

    // Drive one cycle of stimulus at the falling edge, update the model, wait a cycle
    task automatic apply(input logic we, input logic [3:0] be, input logic [31:0] d,
                         input logic lk, input logic sv, input logic [7:0] st,
                         input logic an);
        wr_en = we; wr_be = be; wr_data = d; lock = lk;
        sens_valid = sv; sens_temp = st; mode_analog = an;
        if (we && be[0] && !lk) m_cat = int'(d[7:0]);
        if (we && be[1] && !lk) m_hot = int'(d[15:8]);
        if (we && be[2])        m_aux = int'(d[23:16]);
        if (sv)                 m_samp = int'(st);
        @(negedge clk);
        wr_en = 1'b0; sens_valid = 1'b0;
    endtask

    function automatic string rel_tag();
        int d = m_samp - m_hot;
        if (mode_analog) return "R5 analog readback";
        if (d > 127 || d < -127) return "R4 saturation";
        return "R3 difference";
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        m_aux = 0; m_hot = 0; m_cat = 0; m_samp = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R2 reset value", rd_data, 32'h0);
        check_all("R2 reset rel", "R2 reset targets");

        // R9/R1: plain write of all target lanes, top lane data ignored (R7)
        apply(1, 4'hF, 32'hAB_44_22_11, 0, 0, 8'h00, 0);
        check_all("R7 top lane ignored", "R9 write lands");
        chk("R1 layout", rd_data, {8'(sat_diff(0, 'h22)), 8'h44, 8'h22, 8'h11});

        // R7: single lane write
        apply(1, 4'b0100, 32'hFF_99_77_55, 0, 0, 8'h00, 0);
        check_all("R7 rel", "R7 only aux lane");

        // R3 / R4 corners
        apply(1, 4'b0010, 32'h0000_0000, 0, 1, 8'd255, 0);
        check_all("R4 +255 clips to 127", "R9 hot=0");
        chk("R4 +127", 32'(rd_data[31:24]), 32'h7F);
        apply(1, 4'b0010, 32'h0000_FF00, 0, 1, 8'd0, 0);
        chk("R4 -255 reads 0x81", 32'(rd_data[31:24]), 32'h81);
        apply(1, 4'b0010, 32'h0000_8000, 0, 0, 8'd0, 0);
        chk("R4 -128 reads 0x81", 32'(rd_data[31:24]), 32'h81);
        apply(0, 4'b0000, 32'h0, 0, 1, 8'd255, 0);
        chk("R3 +127 exact", 32'(rd_data[31:24]), 32'h7F);
        apply(0, 4'b0000, 32'h0, 0, 1, 8'd1, 0);
        chk("R3 -127 exact", 32'(rd_data[31:24]), 32'h81);
        apply(0, 4'b0000, 32'h0, 0, 1, 8'd130, 0);
        chk("R3 +2", 32'(rd_data[31:24]), 32'h02);

        // R8: hold without strobe, recompute on hot rewrite
        apply(0, 4'b0000, 32'h0, 0, 0, 8'd10, 0);
        chk("R8 hold without strobe", 32'(rd_data[31:24]), 32'h02);
        apply(1, 4'b0010, 32'h0000_7D00, 0, 0, 8'd99, 0);
        chk("R8 recompute on hot write", 32'(rd_data[31:24]), 32'h05);

        // R5: analog mode returns hot target
        mode_analog = 1'b1; #1;
        chk("R5 analog", 32'(rd_data[31:24]), 32'h7D);
        mode_analog = 1'b0; #1;

        // R6: locked writes
        apply(1, 4'b0111, 32'h00_C3_B2_A1, 1, 0, 8'd0, 0);
        check_all("R6 rel", "R6 lock");
        chk("R6 hot kept", 32'(hot_trip), 32'h7D);
        chk("R6 cat kept", 32'(cat_trip), 32'h55 == 32'(m_cat) ? 32'h55 : 32'(m_cat));
        chk("R6 aux written", 32'(aux_trip), 32'hC3);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic lk_r, an_r;
            lk_r = ($urandom % 4) == 0;
            an_r = ($urandom % 5) == 0;
            apply(($urandom % 2) == 1, 4'($urandom), $urandom, lk_r,
                  ($urandom % 2) == 1, 8'($urandom), an_r);
            check_all(rel_tag(), lk_r ? "R6 random lock" : "R9 random write");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule